// File: doc/BRIEF.md
# Mixed-Signedness Full-Width Multiplier

This block multiplies two W-bit operands (W = 8 by default) and returns the full 2W-bit product. Two mode pins pick, for each operand on its own, whether it is read as unsigned or as two's complement. So the block can form unsigned, signed and mixed (signed-by-unsigned) products.

The block does not take magnitudes and negate them. It first builds one unsigned product from partial-product rows. It then corrects only the upper half: when an operand is marked signed and its top bit is 1, that bit really weighs -2^(W-1) rather than +2^(W-1). To account for this, the other operand is subtracted from the upper half of the product, modulo 2^W. The lower half needs no correction.

Operands enter through a valid/ready handshake, and the product leaves through another one. One register stage holds the result. An operand pair is taken on a rising edge when `in_valid` and `in_ready` are both high. The product is presented with `out_valid` from the next cycle onward. While `out_valid` is high and `out_ready` is low, the result is held and `in_ready` is low, so back-pressure stalls the producer. `in_ready` is high whenever the output register is empty or is being drained in the same cycle.

Top module: `sgnmul`

## Requirements
- R1: With `a_signed`=0 and `b_signed`=0, both operands are read as unsigned, and `out_prod` equals their 2W-bit unsigned product.
- R2: With `a_signed`=1 and `b_signed`=1, both operands are two's complement, and `out_prod` is the two's complement 2W-bit product.
- R3: A mode pin set to 1 marks only its own operand as two's complement, so signed-by-unsigned products are exact in either order.
- R4: The lower W bits of `out_prod` equal the lower W bits of the unsigned product of the same operands in every mode.
- R5: For operands 8'hFF and 8'hFF the product is 16'h0001 when both are signed, 16'hFE01 when both are unsigned, and 16'hFF01 when exactly one is signed.
- R6: A transfer on the input happens on a rising edge with `in_valid`=1 and `in_ready`=1, and `out_valid` is 1 after that edge.
- R7: While `out_valid`=1 and `out_ready`=0, `in_ready` is 0, and `out_valid` and `out_prod` hold their values even if new operands are offered.
- R8: With `in_valid`=0 and `out_ready`=1, `out_valid` is 0 after the next rising edge.
- R9: While `rst_n` is 0 (active low), `out_valid` and `out_prod` are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Block can take an operand pair |
| in_a | input | W | First operand |
| in_b | input | W | Second operand |
| a_signed | input | 1 | 1: `in_a` is two's complement |
| b_signed | input | 1 | 1: `in_b` is two's complement |
| out_valid | output | 1 | Product held in the output register |
| out_ready | input | 1 | Consumer takes the product |
| out_prod | output | 2W | Full-width product |

## Verification
The hardest case to reach is a double correction that borrows past the top of the upper half. This occurs when both operands are signed and negative, and the two subtractions together exceed the raw upper half, as with 8'hFF times 8'hFF. Directed cases drive this pair and a sweep of operands in all four modes. A stall case holds `out_ready` low and offers a different pair, which shows that the held product is not overwritten.

// File: rtl/sgnmul_pkg.sv
package sgnmul_pkg;
  // Signedness selection for one multiply, one bit per operand
  typedef struct packed {
    logic a_twos;
    logic b_twos;
  } sgn_mode_t;
endpackage

// File: rtl/sgnmul_umul.sv
// Unsigned W x W -> 2W product from shifted partial-product rows
module sgnmul_umul #(
  parameter int W = 8
) (
  input  logic [W-1:0]   op_a,
  input  logic [W-1:0]   op_b,
  output logic [2*W-1:0] prod
);
  localparam int PW = 2 * W;

  logic [PW-1:0] row [W];

  for (genvar i = 0; i < W; i++) begin : g_row
    assign row[i] = op_b[i] ? ({{W{1'b0}}, op_a} << i) : '0;
  end

  always_comb begin
    prod = '0;
    for (int k = 0; k < W; k++) begin
      prod = prod + row[k];
    end
  end
endmodule

// File: rtl/sgnmul_hifix.sv
// Corrects the upper half of an unsigned product for negative-weight top bits
module sgnmul_hifix #(
  parameter int W = 8
) (
  input  logic [W-1:0]            op_a,
  input  logic [W-1:0]            op_b,
  input  sgnmul_pkg::sgn_mode_t   mode,
  input  logic [2*W-1:0]          raw,
  output logic [2*W-1:0]          fixed
);
  logic          neg_a;
  logic          neg_b;
  logic [W-1:0]  sub_a;
  logic [W-1:0]  sub_b;
  logic [W-1:0]  hi;

  assign neg_a = mode.a_twos & op_a[W-1];
  assign neg_b = mode.b_twos & op_b[W-1];
  // negative top bit of A removes 2^W * B from the product, and vice versa
  assign sub_a = neg_a ? op_b : '0;
  assign sub_b = neg_b ? op_a : '0;
  // modulo 2^W: borrow out is dropped
  assign hi    = raw[2*W-1:W] - sub_a - sub_b;
  assign fixed = {hi, raw[W-1:0]};
endmodule

// File: rtl/sgnmul_ostage.sv
// One-entry output register with valid/ready handshake
module sgnmul_ostage #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] din,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] dout
);
  logic          vld_q;
  logic [DW-1:0] dat_q;
  logic          take;

  assign in_ready  = !vld_q || out_ready;
  assign take      = in_valid && in_ready;
  assign out_valid = vld_q;
  assign dout      = dat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else if (take) begin
      vld_q <= 1'b1;
      dat_q <= din;
    end else if (out_ready) begin
      vld_q <= 1'b0;
    end
  end
endmodule

// File: rtl/sgnmul.sv
module sgnmul #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [W-1:0]   in_a,
  input  logic [W-1:0]   in_b,
  input  logic           a_signed,
  input  logic           b_signed,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [2*W-1:0] out_prod
);
  localparam int PW = 2 * W;

  sgnmul_pkg::sgn_mode_t mode;
  logic [PW-1:0] raw_p;
  logic [PW-1:0] fix_p;

  assign mode.a_twos = a_signed;
  assign mode.b_twos = b_signed;

  sgnmul_umul #(.W(W)) u_umul (
    .op_a (in_a),
    .op_b (in_b),
    .prod (raw_p)
  );

  sgnmul_hifix #(.W(W)) u_fix (
    .op_a  (in_a),
    .op_b  (in_b),
    .mode  (mode),
    .raw   (raw_p),
    .fixed (fix_p)
  );

  sgnmul_ostage #(.DW(PW)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .din       (fix_p),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .dout      (out_prod)
  );
endmodule

// File: rtl/sgnmul_chk.sv
module sgnmul_chk #(
  parameter int W = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic           in_ready,
  input logic [W-1:0]   in_a,
  input logic [W-1:0]   in_b,
  input logic           a_signed,
  input logic           b_signed,
  input logic           out_valid,
  input logic           out_ready,
  input logic [2*W-1:0] out_prod
);
  logic [2*W-1:0] ref_p;
  logic [2*W-1:0] ref_u;
  logic           acc;

  assign acc   = in_valid && in_ready;
  assign ref_p = {{W{a_signed & in_a[W-1]}}, in_a} * {{W{b_signed & in_b[W-1]}}, in_b};
  assign ref_u = {{W{1'b0}}, in_a} * {{W{1'b0}}, in_b};

  // R1
  unsigned_prod_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !a_signed && !b_signed) |=> out_prod == $past(ref_u));
  // R2
  signed_prod_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && a_signed && b_signed) |=> out_prod == $past(ref_p));
  // R3
  mixed_prod_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (a_signed != b_signed)) |=> out_prod == $past(ref_p));
  // R4
  low_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_prod[W-1:0] == $past(ref_u[W-1:0]));
  // R6
  accept_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);
  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_prod)));
  // R7
  stall_noready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
  // R8
  drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && out_ready) |=> !out_valid);
endmodule

bind sgnmul sgnmul_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_a      (in_a),
  .in_b      (in_b),
  .a_signed  (a_signed),
  .b_signed  (b_signed),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_prod  (out_prod)
);

// File: tb/sgnmul_tb.sv
`timescale 1ns/1ps
module sgnmul_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [7:0]  in_a;
  logic [7:0]  in_b;
  logic        a_signed;
  logic        b_signed;
  logic        out_valid;
  logic        out_ready;
  logic [15:0] out_prod;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  sgnmul #(.W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .a_signed(a_signed), .b_signed(b_signed),
    .out_valid(out_valid), .out_ready(out_ready), .out_prod(out_prod)
  );

  function automatic logic [15:0] model(input logic [7:0] a, input logic [7:0] b,
                                        input logic sa, input logic sb);
    int va;
    int vb;
    int p;
    va = int'(a);
    vb = int'(b);
    if (sa && a[7]) va = va - 256;
    if (sb && b[7]) vb = vb - 256;
    p = va * vb;
    return p[15:0];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one pair, take it, and return the product seen one cycle later
  task automatic mul_one(input logic [7:0] a, input logic [7:0] b, input logic sa,
                         input logic sb, output logic [15:0] p, output logic v);
    @(negedge clk);
    in_a = a; in_b = b; a_signed = sa; b_signed = sb;
    in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    p = out_prod;
    v = out_valid;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    in_a = '0; in_b = '0; a_signed = 1'b0; b_signed = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 out_valid in reset", {31'b0, out_valid}, 32'd0);
    check("R9 out_prod in reset", {16'b0, out_prod}, 32'd0);
    rst_n = 1'b1;
  endtask

  task automatic t_mode(input string req, input logic sa, input logic sb);
    logic [15:0] p;
    logic v;
    for (int i = 0; i < 24; i++) begin
      logic [7:0] a;
      logic [7:0] b;
      a = 8'(i * 37 + 5);
      b = 8'(i * 91 + 130);
      mul_one(a, b, sa, sb, p, v);
      check(req, {16'b0, p}, {16'b0, model(a, b, sa, sb)});
      // R4: low half independent of mode
      check("R4 low half", {24'b0, p[7:0]}, {24'b0, 8'(a * b)});
      // R6
      check("R6 out_valid after accept", {31'b0, v}, 32'd1);
    end
  endtask

  task automatic t_corner();
    logic [15:0] p;
    logic v;
    mul_one(8'hFF, 8'hFF, 1'b1, 1'b1, p, v);
    check("R5 FFxFF signed", {16'b0, p}, 32'h0001);
    mul_one(8'hFF, 8'hFF, 1'b0, 1'b0, p, v);
    check("R5 FFxFF unsigned", {16'b0, p}, 32'hFE01);
    mul_one(8'hFF, 8'hFF, 1'b1, 1'b0, p, v);
    check("R5 FFxFF a signed", {16'b0, p}, 32'hFF01);
    mul_one(8'hFF, 8'hFF, 1'b0, 1'b1, p, v);
    check("R5 FFxFF b signed", {16'b0, p}, 32'hFF01);
    mul_one(8'h80, 8'h80, 1'b1, 1'b1, p, v);
    check("R2 80x80 signed", {16'b0, p}, 32'h4000);
    mul_one(8'h80, 8'hFF, 1'b1, 1'b0, p, v);
    check("R3 80s x FFu", {16'b0, p}, 32'h8080);
    mul_one(8'h7F, 8'h80, 1'b0, 1'b1, p, v);
    check("R3 7Fu x 80s", {16'b0, p}, 32'hC080);
  endtask

  task automatic t_stall();
    @(negedge clk);
    in_a = 8'h12; in_b = 8'h34; a_signed = 1'b0; b_signed = 1'b0;
    in_valid = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    check("R6 valid after stalled accept", {31'b0, out_valid}, 32'd1);
    check("R7 in_ready low while stalled", {31'b0, in_ready}, 32'd0);
    in_a = 8'hFF; in_b = 8'hFF; a_signed = 1'b1; b_signed = 1'b1;
    repeat (3) @(negedge clk);
    check("R7 product held", {16'b0, out_prod}, 32'h03A8);
    check("R7 valid held", {31'b0, out_valid}, 32'd1);
    in_valid = 1'b0; out_ready = 1'b1;
    @(negedge clk);
    check("R8 drained", {31'b0, out_valid}, 32'd0);
    check("R8 in_ready after drain", {31'b0, in_ready}, 32'd1);
    check("R7 product kept after drain", {16'b0, out_prod}, 32'h03A8);
  endtask

  task automatic t_back2back();
    // accept while draining: next product replaces old one without a gap
    @(negedge clk);
    in_a = 8'h03; in_b = 8'hFE; a_signed = 1'b0; b_signed = 1'b1;
    in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    check("R3 first of pair", {16'b0, out_prod}, 32'hFFFA);
    in_a = 8'hFE; in_b = 8'h03; a_signed = 1'b1; b_signed = 1'b0;
    @(negedge clk);
    check("R6 back-to-back valid", {31'b0, out_valid}, 32'd1);
    check("R3 second of pair", {16'b0, out_prod}, 32'hFFFA);
    in_valid = 1'b0;
    @(negedge clk);
    check("R8 idle drain", {31'b0, out_valid}, 32'd0);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_mode("R1 unsigned", 1'b0, 1'b0);
        t_mode("R2 signed", 1'b1, 1'b1);
        t_mode("R3 a signed", 1'b1, 1'b0);
        t_mode("R3 b signed", 1'b0, 1'b1);
        t_corner();
        t_stall();
        t_back2back();
        // R9: reset in mid-stream clears the held product
        @(negedge clk);
        in_a = 8'h55; in_b = 8'h02; in_valid = 1'b1; out_ready = 1'b0;
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check("R9 valid cleared", {31'b0, out_valid}, 32'd0);
        check("R9 product cleared", {16'b0, out_prod}, 32'd0);
        rst_n = 1'b1;
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule